// File: doc/BRIEF.md
# Clocked-Serial Byte Receiver

This block takes in 8-bit frames over a two-wire clocked serial link, where the sender drives a serial clock alongside the data. It hands each byte to a host through a small register interface. The serial clock and data pins are brought into the system clock domain through a two-flop synchroniser. A data bit is taken on every rising edge of the serial clock, least significant bit first, so bit 7 arrives last. A finished byte goes into a receive data register and raises a data-full flag. While the interrupt enable is set, the flag drives a level interrupt request.

The host sees three registers, selected by `reg_addr`. Address 0 is control: bit 0 is receive enable and bit 1 is interrupt enable. Address 1 is status: bit 0 is data-full, bit 1 is overrun, bit 2 is framing error and bit 3 is parity error. Address 2 is the received byte. Address 3 reads as zero. A status flag is cleared by writing 0 to its bit, and only after a status read has returned that bit as 1. A DMA engine can instead pulse `dma_rd`. This drives the data register onto `reg_rdata` and clears data-full in the same step.

A pending overrun, framing or parity error halts reception until software clears it. The two error inputs stay behind from an earlier asynchronous mode and only set their flags. `rst_n` is asserted asynchronously and is expected to be released in step with `clk`.

Top module: `csync_rx`

## Requirements
- R1: Bits are taken on serial clock rising edges, LSB first. After the eighth bit, the byte reads back at address 2 with the first bit received in bit 0 and the last in bit 7.
- R2: When a byte completes and data-full is 0, the byte is loaded into the data register and data-full (status bit 0) becomes 1.
- R3: When a byte completes while data-full is 1, overrun (status bit 1) becomes 1 and the data register keeps its previous byte.
- R4: While overrun, framing error or parity error is 1, incoming bits are discarded, no byte completes, and data-full is not set.
- R5: A one-cycle `dma_rd` pulse shows the data register on `reg_rdata` and clears data-full. A byte that completes in that same cycle with data-full at 1 still sets overrun.
- R6: A write of 0 to a status bit clears it only if a status read has returned that bit as 1 since it last became 1. Writing 1, or writing 0 without such a read, leaves the flag unchanged.
- R7: `rx_irq` is 1 exactly while data-full and interrupt enable (control bit 1) are both 1.
- R8: While receive enable (control bit 0) is 0, no byte is received, and a partly received byte is discarded when enable drops.
- R9: A pulse on `frm_err_set` sets status bit 2, and a pulse on `par_err_set` sets status bit 3.
- R10: After reset every register and flag reads 0 and `rx_irq` is 0. The control register reads back what was written to bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ser_clk | input | 1 | Incoming serial clock (asynchronous) |
| ser_dat | input | 1 | Incoming serial data (asynchronous) |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data (data register while `dma_rd`, else selected register while `reg_rd`, else 0) |
| dma_rd | input | 1 | DMA read strobe of the data register, clears data-full |
| frm_err_set | input | 1 | Sets the framing-error flag |
| par_err_set | input | 1 | Sets the parity-error flag |
| rx_irq | output | 1 | Receive-full interrupt request, level |

## Verification
Two events can fall in one cycle: a byte completes, and a DMA read clears data-full. The bench sets this up by timing the `dma_rd` pulse to the exact system clock edge at which the synchronised last serial rising edge completes the byte, while the previous byte is still unread. A cycle-level reference model then expects overrun set, data-full clear and the old byte kept. A status read and a data read close the case.

// File: rtl/csync_rx_pkg.sv
package csync_rx_pkg;
  localparam int ADDR_W = 2;
  localparam int NFLAG  = 4;
  // flag positions inside the status register
  localparam int F_FULL = 0;
  localparam int F_OVR  = 1;
  localparam int F_FER  = 2;
  localparam int F_PER  = 3;
  // register select codes
  localparam logic [ADDR_W-1:0] A_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
endpackage

// File: rtl/csync_rx_sync.sv
module csync_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_dat,
  output logic rise,
  output logic bit_val
);
  logic [STAGES:0]   sck_q, sck_d;
  logic [STAGES-1:0] sdi_q, sdi_d;

  always_comb begin
    sck_d   = {sck_q[STAGES-1:0], ser_clk};
    sdi_d   = {sdi_q[STAGES-2:0], ser_dat};
    rise    = sck_q[STAGES-1] & ~sck_q[STAGES];
    bit_val = sdi_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      sdi_q <= '0;
    end else begin
      sck_q <= sck_d;
      sdi_q <= sdi_d;
    end
  end
endmodule

// File: rtl/csync_rx_shift.sv
module csync_rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rise,
  input  logic              bit_val,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_byte
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              sr_en;

  always_comb begin
    sr_en      = run & rise;
    sr_d       = {bit_val, sr_q[DATA_W-1:1]};
    frame_byte = sr_d;
    frame_done = sr_en & (cnt_q == LAST);
    if (!run)
      cnt_d = '0;
    else if (rise)
      cnt_d = frame_done ? '0 : cnt_q + CNT_W'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end
endmodule

// File: rtl/csync_rx_regs.sv
module csync_rx_regs
  import csync_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dma_rd,
  input  logic              frm_err_set,
  input  logic              par_err_set,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_byte,
  output logic              rx_en,
  output logic [NFLAG-1:0]  flags,
  output logic              rx_irq
);
  logic              en_q, ie_q;
  logic [NFLAG-1:0]  flg_q, flg_d, arm_q, arm_d, set_v, clr_v;
  logic [DATA_W-1:0] rdr_q;
  logic              ctl_wr, st_wr, st_rd, rdr_ld;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NFLAG];

  always_comb begin
    ctl_wr = reg_wr & (reg_addr == A_CTL);
    st_wr  = reg_wr & (reg_addr == A_STAT);
    st_rd  = reg_rd & (reg_addr == A_STAT);
    set_v  = {par_err_set, frm_err_set,
              frame_done & flg_q[F_FULL], frame_done & ~flg_q[F_FULL]};
    rdr_ld = set_v[F_FULL];
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    if (g == F_FULL) begin : g_dma
      assign clr_v[g] = (st_wr & ~reg_wdata[g] & arm_q[g]) | dma_rd;
    end else begin : g_sw
      assign clr_v[g] = st_wr & ~reg_wdata[g] & arm_q[g];
    end
    assign flg_d[g] = set_v[g] | (flg_q[g] & ~clr_v[g]);
    assign arm_d[g] = flg_d[g] & (arm_q[g] | (st_rd & flg_q[g]));
  end

  always_comb begin
    reg_rdata = '0;
    if (dma_rd)
      reg_rdata = rdr_q;
    else if (reg_rd) begin
      case (reg_addr)
        A_CTL:   reg_rdata = {{(DATA_W-2){1'b0}}, ie_q, en_q};
        A_STAT:  reg_rdata = {{(DATA_W-NFLAG){1'b0}}, flg_q};
        A_DATA:  reg_rdata = rdr_q;
        default: reg_rdata = '0;
      endcase
    end
    rx_en  = en_q;
    flags  = flg_q;
    rx_irq = flg_q[F_FULL] & ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q <= reg_wdata[0];
      ie_q <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      arm_q <= '0;
    end else begin
      flg_q <= flg_d;
      arm_q <= arm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdr_q <= '0;
    else if (rdr_ld) rdr_q <= frame_byte;
  end
endmodule

// File: rtl/csync_rx.sv
module csync_rx
  import csync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dma_rd,
  input  logic              frm_err_set,
  input  logic              par_err_set,
  output logic              rx_irq
);
  logic              rise, bit_val, run, stall, rx_en, frame_done;
  logic [DATA_W-1:0] frame_byte;
  logic [NFLAG-1:0]  flags;

  assign stall = flags[F_OVR] | flags[F_FER] | flags[F_PER];
  assign run   = rx_en & ~stall;

  csync_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .rise(rise), .bit_val(bit_val)
  );

  csync_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(run), .rise(rise), .bit_val(bit_val),
    .frame_done(frame_done), .frame_byte(frame_byte)
  );

  csync_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_rd(dma_rd), .frm_err_set(frm_err_set), .par_err_set(par_err_set),
    .frame_done(frame_done), .frame_byte(frame_byte),
    .rx_en(rx_en), .flags(flags), .rx_irq(rx_irq)
  );
endmodule

// File: rtl/csync_rx_chk.sv
module csync_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_rd,
  input logic frame_done,
  input logic full,
  input logic ovr,
  input logic stall,
  input logic rx_en
);
  AST_FILL_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !full |=> full); // R2
  AST_OVR_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && full |=> ovr); // R3
  AST_STALL_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !full |=> !full); // R4
  AST_DMA_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd && !frame_done |=> !full); // R5
  AST_OFF_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !frame_done); // R8
endmodule

bind csync_rx csync_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dma_rd(dma_rd), .frame_done(frame_done),
  .full(flags[0]), .ovr(flags[1]), .stall(stall), .rx_en(rx_en)
);

// File: tb/sim_csync_rx.sv
module sim_csync_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0, dma_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       frm_err_set = 1'b0, par_err_set = 1'b0;
  logic       rx_irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  csync_rx u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_rd(dma_rd),
    .frm_err_set(frm_err_set), .par_err_set(par_err_set), .rx_irq(rx_irq)
  );

  // behavioural reference
  bit       m_en, m_ie;
  bit       m_f[4];
  bit       m_arm[4];
  bit [7:0] m_rdr;
  bit       h_sck[3], h_sdi[3];
  bit       m_bits[$];

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] m_status();
    return {4'd0, m_f[3], m_f[2], m_f[1], m_f[0]};
  endfunction

  function automatic bit [7:0] m_rdata();
    if (dma_rd) return m_rdr;
    if (!reg_rd) return 8'd0;
    case (reg_addr)
      2'd0: return {6'd0, m_ie, m_en};
      2'd1: return m_status();
      2'd2: return m_rdr;
      default: return 8'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_rdr = 0;
      foreach (m_f[i]) begin m_f[i] = 0; m_arm[i] = 0; end
      foreach (h_sck[i]) begin h_sck[i] = 0; h_sdi[i] = 0; end
      m_bits.delete();
    end else begin
      bit old_f[4];
      bit run, edge_s, done, st_rd, st_wr;
      bit set_f[4];
      bit [7:0] byte_v;
      old_f = m_f;
      run = m_en && !(old_f[1] || old_f[2] || old_f[3]);
      edge_s = h_sck[1] && !h_sck[2];
      done = 0;
      byte_v = 0;
      if (!run) m_bits.delete();
      else if (edge_s) begin
        m_bits.push_back(h_sdi[1]);
        if (m_bits.size() == 8) begin
          for (int i = 0; i < 8; i++) byte_v[i] = m_bits[i];
          m_bits.delete();
          done = 1;
        end
      end
      st_rd = reg_rd && reg_addr == 2'd1;
      st_wr = reg_wr && reg_addr == 2'd1;
      set_f[0] = done && !old_f[0];
      set_f[1] = done && old_f[0];
      set_f[2] = frm_err_set;
      set_f[3] = par_err_set;
      for (int i = 0; i < 4; i++) begin
        bit clr;
        clr = (st_wr && !reg_wdata[i] && m_arm[i]) || (i == 0 && dma_rd);
        if (set_f[i]) m_f[i] = 1;
        else if (clr) m_f[i] = 0;
        m_arm[i] = m_f[i] && (m_arm[i] || (st_rd && old_f[i]));
      end
      if (set_f[0]) m_rdr = byte_v;
      if (reg_wr && reg_addr == 2'd0) begin
        m_en = reg_wdata[0];
        m_ie = reg_wdata[1];
      end
      h_sck[2] = h_sck[1]; h_sck[1] = h_sck[0]; h_sck[0] = ser_clk;
      h_sdi[2] = h_sdi[1]; h_sdi[1] = h_sdi[0]; h_sdi[0] = ser_dat;
    end
    #2;
    if (rst_n) begin
      check("R7 irq", rx_irq, m_f[0] && m_ie);
      check(dma_rd ? "R5 rdata" : "R6 rdata", reg_rdata, m_rdata());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd_expect(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #5 check(tag, reg_rdata, exp);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic dma_pulse();
    @(negedge clk); dma_rd = 1;
    @(negedge clk); dma_rd = 0;
  endtask

  task automatic send_bits(logic [7:0] b, int n, bit dma_at_end);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ser_clk = 0; ser_dat = b[i];
      idle(1);
      @(negedge clk); ser_clk = 1;
      if (dma_at_end && i == n - 1) begin
        @(negedge clk);
        @(negedge clk); dma_rd = 1;
        @(negedge clk); dma_rd = 0;
      end else idle(1);
    end
    @(negedge clk); ser_clk = 0;
    idle(4);
  endtask

  task automatic pulse_err(bit par);
    @(negedge clk); if (par) par_err_set = 1; else frm_err_set = 1;
    @(negedge clk); par_err_set = 0; frm_err_set = 0;
  endtask

  task automatic clear_status(logic [7:0] seen);
    rd_expect(2'd1, seen, "R6 read before clear");
    wr(2'd1, 8'h00);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    #5 check("R10 irq after reset", rx_irq, 0);
    rd_expect(2'd0, 8'h00, "R10 ctrl reset");
    rd_expect(2'd1, 8'h00, "R10 status reset");
    rd_expect(2'd2, 8'h00, "R10 data reset");
    wr(2'd0, 8'h03);
    rd_expect(2'd0, 8'h03, "R10 ctrl readback");

    // R1 R2 R7: first byte
    send_bits(8'hA5, 8, 0);
    check("R7 irq high", rx_irq, 1);
    // R6: write 0 before any read leaves the flag
    wr(2'd1, 8'h00);
    rd_expect(2'd1, 8'h01, "R6 unarmed clear ignored / R2 full");
    wr(2'd1, 8'hFF);
    rd_expect(2'd1, 8'h01, "R6 write one ignored");
    rd_expect(2'd2, 8'hA5, "R1 byte order");
    wr(2'd1, 8'h00);
    rd_expect(2'd1, 8'h00, "R6 armed clear");
    check("R7 irq low", rx_irq, 0);

    // R5: DMA clears full
    send_bits(8'h3C, 8, 0);
    dma_pulse();
    rd_expect(2'd1, 8'h00, "R5 dma clear");
    rd_expect(2'd2, 8'h3C, "R1 second byte");

    // R3: overrun keeps old byte; R4: reception halts
    send_bits(8'h11, 8, 0);
    send_bits(8'h22, 8, 0);
    rd_expect(2'd2, 8'h11, "R3 data kept");
    send_bits(8'h44, 8, 0);
    rd_expect(2'd2, 8'h11, "R4 halted by overrun");
    clear_status(8'h03);
    rd_expect(2'd1, 8'h00, "R3 cleared");

    // R8: disable discards partial byte
    send_bits(8'hFF, 3, 0);
    wr(2'd0, 8'h02);
    send_bits(8'h77, 8, 0);
    rd_expect(2'd1, 8'h00, "R8 disabled no byte");
    wr(2'd0, 8'h03);
    send_bits(8'h5A, 8, 0);
    rd_expect(2'd2, 8'h5A, "R8 partial discarded");
    dma_pulse();

    // R9 and R4 with error flags
    pulse_err(0);
    rd_expect(2'd1, 8'h04, "R9 framing flag");
    send_bits(8'h99, 8, 0);
    rd_expect(2'd1, 8'h04, "R4 halted by framing");
    wr(2'd1, 8'h00);
    rd_expect(2'd1, 8'h00, "R6 framing cleared");
    pulse_err(1);
    send_bits(8'h66, 4, 0);
    clear_status(8'h08);
    send_bits(8'hC3, 8, 0);
    rd_expect(2'd2, 8'hC3, "R4 resumes after clear");

    // R5 with coincident completion: overrun set, full cleared
    send_bits(8'h0F, 8, 1);
    rd_expect(2'd1, 8'h02, "R5 coincident dma and byte");
    rd_expect(2'd2, 8'hC3, "R3 coincident data kept");
    wr(2'd1, 8'h00);
    rd_expect(2'd1, 8'h00, "R6 overrun cleared");

    idle(5);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule